// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the fault-confinement bookkeeping of a CAN node. It holds two separate counters, one for receive errors and one for transmit errors. From their values it derives which of the three node conditions applies: fully active on the bus, passive (it may still take part but signals errors only weakly), or disconnected from the bus (bus-off). A bit stream processor elsewhere decides which error or success event occurred. It tells this block through single-cycle command strobes. The block only applies those commands to the counters.

A node that has gone bus-off comes back only through a recovery sequence. The bit stream processor pulses a run strobe each time it observes eleven consecutive recessive bits. After a parameterised number of such runs, both counters clear and the node is active again. A synchronous reset gives the same clean state.

Top module: `can_fault_guard`

## Requirements
- R1: After a synchronous reset both counters read 0, `errActive` is 1, and `errPassive` and `busOff` are 0.
- R2: `recInc1` adds 1 and `recInc8` adds 8 to the receive counter. The sum saturates at 255 and never wraps. When both strobes are high together, only 8 is added.
- R3: `recDec` and `tecDec` leave a counter at 0 when it is already 0. When the receive counter is above 127, `recDec` sets it to 120. Otherwise `recDec` subtracts 1.
- R4: `tecInc8` adds 8 to the transmit counter and `tecDec` subtracts 1 from it.
- R5: When an increment and a decrement for the same counter are high in the same cycle, the increment is applied and the decrement is dropped. Commands to the two counters in one cycle are both applied.
- R6: Exactly one of `errActive`, `errPassive` and `busOff` is 1 at all times. `errPassive` is 1 when either counter is 128 or more and the node is not bus-off.
- R7: `busOff` is 1 whenever the transmit counter exceeds 255. While `busOff` is 1, all counter commands are ignored and both counters hold.
- R8: While the node is bus-off, the 128th `recessRun` pulse clears both counters, and the node is active again on the next cycle. `recessRun` pulses that arrive while the node is not bus-off are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| recInc1 | input | 1 | Add 1 to the receive counter |
| recInc8 | input | 1 | Add 8 to the receive counter |
| recDec | input | 1 | Decrement the receive counter |
| tecInc8 | input | 1 | Add 8 to the transmit counter |
| tecDec | input | 1 | Decrement the transmit counter |
| recessRun | input | 1 | One pulse per run of 11 recessive bits |
| recCount | output | 8 | Receive error counter |
| tecCount | output | 9 | Transmit error counter |
| errActive | output | 1 | Node is error-active |
| errPassive | output | 1 | Node is error-passive |
| busOff | output | 1 | Node is bus-off |

## Verification
Every command strobe is captured by the counter registers at the clock edge where it is high. The new counter value and the state flags that depend on it are therefore valid one cycle later; the flags are combinational from the registered counters. The recovery pulse that completes the count clears the counters at that same edge, so the node reads error-active in the following cycle. The bench drives each stimulus for exactly one edge, then samples all outputs 1 ns after that edge, well before the next one. This places every check in the first cycle the result is due.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
package fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_OFF     = 2'd2
  } fcState_t;

  typedef struct packed {
    logic recUp1;
    logic recUp8;
    logic recDown;
    logic tecUp8;
    logic tecDown;
    logic clearAll;
  } fcStrobes_t;

endpackage

// File: rtl/fc_datapath.sv
`timescale 1ns/1ps
module fc_datapath
  import fc_pkg::*;
#(
  parameter int REC_W        = 8,
  parameter int TEC_W        = 9,
  parameter int STEP_BIG     = 8,
  parameter int PASSIVE_LIM  = 128,
  parameter int REC_FALLBACK = 120
) (
  input  logic             clk,
  input  logic             rst,
  input  fcStrobes_t       strb,
  output logic [REC_W-1:0] recVal,
  output logic [TEC_W-1:0] tecVal
);

  localparam logic [REC_W-1:0] REC_MAX  = '1;
  localparam logic [TEC_W-1:0] TEC_MAX  = '1;
  localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASSIVE_LIM);
  localparam logic [REC_W-1:0] REC_BACK = REC_W'(REC_FALLBACK);
  localparam logic [REC_W:0]   REC_BIG  = (REC_W+1)'(STEP_BIG);
  localparam logic [REC_W:0]   REC_ONE  = (REC_W+1)'(1);
  localparam logic [TEC_W:0]   TEC_BIG  = (TEC_W+1)'(STEP_BIG);

  logic [REC_W-1:0] recNext;
  logic [TEC_W-1:0] tecNext;
  logic [REC_W:0]   recSum;
  logic [TEC_W:0]   tecSum;

  // Receive counter: increments win over decrement, big step wins over small.
  always_comb begin
    recSum = {1'b0, recVal} + (strb.recUp8 ? REC_BIG : REC_ONE);
    recNext = recVal;
    if (strb.clearAll) begin
      recNext = '0;
    end else if (strb.recUp8 || strb.recUp1) begin
      recNext = recSum[REC_W] ? REC_MAX : recSum[REC_W-1:0];
    end else if (strb.recDown) begin
      if (recVal >= REC_PASS) begin
        recNext = REC_BACK;
      end else if (recVal != '0) begin
        recNext = recVal - 1'b1;
      end
    end
  end

  // Transmit counter: the sum may pass the bus-off limit, that is intended.
  always_comb begin
    tecSum = {1'b0, tecVal} + TEC_BIG;
    tecNext = tecVal;
    if (strb.clearAll) begin
      tecNext = '0;
    end else if (strb.tecUp8) begin
      tecNext = tecSum[TEC_W] ? TEC_MAX : tecSum[TEC_W-1:0];
    end else if (strb.tecDown) begin
      if (tecVal != '0) begin
        tecNext = tecVal - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      recVal <= '0;
      tecVal <= '0;
    end else begin
      recVal <= recNext;
      tecVal <= tecNext;
    end
  end

  AST_REC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (strb.recUp1 || strb.recUp8) && !strb.clearAll |=> recVal >= $past(recVal)); // R2

  AST_TEC_FLOOR: assert property (@(posedge clk) disable iff (rst)
    strb.tecDown && !strb.tecUp8 && !strb.clearAll && tecVal == '0 |=> tecVal == '0); // R3

  AST_REC_FLOOR: assert property (@(posedge clk) disable iff (rst)
    strb.recDown && !strb.recUp1 && !strb.recUp8 && !strb.clearAll && recVal == '0
    |=> recVal == '0); // R3

  AST_INC_WINS: assert property (@(posedge clk) disable iff (rst)
    strb.tecUp8 && strb.tecDown && !strb.clearAll && tecVal < TEC_MAX
    |=> tecVal > $past(tecVal)); // R5

endmodule

// File: rtl/fc_ctrl.sv
`timescale 1ns/1ps
module fc_ctrl
  import fc_pkg::*;
#(
  parameter int REC_W        = 8,
  parameter int TEC_W        = 9,
  parameter int PASSIVE_LIM  = 128,
  parameter int BUSOFF_LIM   = 256,
  parameter int RECOVER_RUNS = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             recInc1,
  input  logic             recInc8,
  input  logic             recDec,
  input  logic             tecInc8,
  input  logic             tecDec,
  input  logic             recessRun,
  input  logic [REC_W-1:0] recVal,
  input  logic [TEC_W-1:0] tecVal,
  output fcStrobes_t       strb,
  output fcState_t         nodeState
);

  localparam int RUN_W = (RECOVER_RUNS > 1) ? $clog2(RECOVER_RUNS) : 1;
  localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(BUSOFF_LIM);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RECOVER_RUNS - 1);

  logic [RUN_W-1:0] runCount;
  logic             isOff;
  logic             runDone;

  // Node condition comes only from the present counter values.
  always_comb begin
    isOff = (tecVal >= TEC_OFF);
    if (isOff) begin
      nodeState = FC_OFF;
    end else if (recVal >= REC_PASS || tecVal >= TEC_PASS) begin
      nodeState = FC_PASSIVE;
    end else begin
      nodeState = FC_ACTIVE;
    end
  end

  assign runDone = isOff && recessRun && (runCount == RUN_LAST);

  // Commands pass only while the node is on the bus.
  always_comb begin
    strb.recUp1   = recInc1 && !isOff;
    strb.recUp8   = recInc8 && !isOff;
    strb.recDown  = recDec  && !isOff;
    strb.tecUp8   = tecInc8 && !isOff;
    strb.tecDown  = tecDec  && !isOff;
    strb.clearAll = runDone;
  end

  // Recovery run counter, idle at zero outside bus-off.
  always_ff @(posedge clk) begin
    if (rst) begin
      runCount <= '0;
    end else if (!isOff || runDone) begin
      runCount <= '0;
    end else if (recessRun) begin
      runCount <= runCount + 1'b1;
    end
  end

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
    nodeState == FC_ACTIVE || nodeState == FC_PASSIVE || nodeState == FC_OFF); // R6

  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
    isOff && !recessRun |=> $stable(recVal) && $stable(tecVal)); // R7

  AST_RECOVER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    runDone |=> recVal == '0 && tecVal == '0 && nodeState == FC_ACTIVE); // R8

  AST_RUN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !isOff |=> runCount == '0); // R8

endmodule

// File: rtl/can_fault_guard.sv
`timescale 1ns/1ps
module can_fault_guard
  import fc_pkg::*;
#(
  parameter int REC_W        = 8,
  parameter int TEC_W        = 9,
  parameter int STEP_BIG     = 8,
  parameter int PASSIVE_LIM  = 128,
  parameter int BUSOFF_LIM   = 256,
  parameter int RECOVER_RUNS = 128,
  parameter int REC_FALLBACK = 120
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             recInc1,
  input  logic             recInc8,
  input  logic             recDec,
  input  logic             tecInc8,
  input  logic             tecDec,
  input  logic             recessRun,
  output logic [REC_W-1:0] recCount,
  output logic [TEC_W-1:0] tecCount,
  output logic             errActive,
  output logic             errPassive,
  output logic             busOff
);

  fcStrobes_t strb;
  fcState_t   nodeState;

  fc_ctrl #(
    .REC_W(REC_W), .TEC_W(TEC_W), .PASSIVE_LIM(PASSIVE_LIM),
    .BUSOFF_LIM(BUSOFF_LIM), .RECOVER_RUNS(RECOVER_RUNS)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .recInc1(recInc1), .recInc8(recInc8), .recDec(recDec),
    .tecInc8(tecInc8), .tecDec(tecDec), .recessRun(recessRun),
    .recVal(recCount), .tecVal(tecCount),
    .strb(strb), .nodeState(nodeState)
  );

  fc_datapath #(
    .REC_W(REC_W), .TEC_W(TEC_W), .STEP_BIG(STEP_BIG),
    .PASSIVE_LIM(PASSIVE_LIM), .REC_FALLBACK(REC_FALLBACK)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .recVal(recCount), .tecVal(tecCount)
  );

  assign errActive  = (nodeState == FC_ACTIVE);
  assign errPassive = (nodeState == FC_PASSIVE);
  assign busOff     = (nodeState == FC_OFF);

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot({errActive, errPassive, busOff})); // R6

endmodule

// File: tb/sim_can_fault_guard.sv
`timescale 1ns/1ps
module sim_can_fault_guard;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic recInc1 = 0, recInc8 = 0, recDec = 0, tecInc8 = 0, tecDec = 0, recessRun = 0;
  logic [7:0] recCount;
  logic [8:0] tecCount;
  logic errActive, errPassive, busOff;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  can_fault_guard u0 (
    .clk(clk), .rst(rst), .recInc1(recInc1), .recInc8(recInc8), .recDec(recDec),
    .tecInc8(tecInc8), .tecDec(tecDec), .recessRun(recessRun),
    .recCount(recCount), .tecCount(tecCount),
    .errActive(errActive), .errPassive(errPassive), .busOff(busOff)
  );

  // {recInc1, recInc8, recDec, tecInc8, tecDec, expected rec, expected tec}
  localparam logic [21:0] VECS [10] = '{
    {5'b10000, 8'd1,  9'd0},
    {5'b01000, 8'd9,  9'd0},
    {5'b00100, 8'd8,  9'd0},
    {5'b10100, 8'd9,  9'd0},
    {5'b00010, 8'd9,  9'd8},
    {5'b00001, 8'd9,  9'd7},
    {5'b00011, 8'd9,  9'd15},
    {5'b11000, 8'd17, 9'd15},
    {5'b01001, 8'd25, 9'd14},
    {5'b00101, 8'd24, 9'd13}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [4:0] c, input logic run);
    {recInc1, recInc8, recDec, tecInc8, tecDec} = c;
    recessRun = run;
    @(posedge clk);
    #1;
    {recInc1, recInc8, recDec, tecInc8, tecDec} = 5'b0;
    recessRun = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic flags(input string req, input logic a, input logic p, input logic o);
    chk(req, {errActive, errPassive, busOff}, {a, p, o});
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    chk("R1 rec", recCount, 0);
    chk("R1 tec", tecCount, 0);
    flags("R1 flags", 1, 0, 0);

    // R2 R4 R5 vector walk
    for (int i = 0; i < 10; i++) begin
      cyc(VECS[i][21:17], 1'b0);
      chk($sformatf("R5 vec%0d rec", i), recCount, VECS[i][16:9]);
      chk($sformatf("R4 vec%0d tec", i), tecCount, VECS[i][8:0]);
      flags("R6 vec active", 1, 0, 0);
    end

    // R3 floors at zero
    doReset();
    cyc(5'b00101, 1'b0);
    chk("R3 rec floor", recCount, 0);
    chk("R3 tec floor", tecCount, 0);

    // R6 passive through rec, R3 fallback
    for (int i = 0; i < 15; i++) cyc(5'b01000, 1'b0);
    chk("R2 rec 120", recCount, 120);
    flags("R6 still active", 1, 0, 0);
    cyc(5'b01000, 1'b0);
    chk("R2 rec 128", recCount, 128);
    flags("R6 passive rec", 0, 1, 0);
    cyc(5'b00100, 1'b0);
    chk("R3 fallback", recCount, 120);
    flags("R6 back active", 1, 0, 0);

    // R2 saturation
    for (int i = 0; i < 20; i++) cyc(5'b01000, 1'b0);
    chk("R2 saturate", recCount, 255);
    cyc(5'b10000, 1'b0);
    chk("R2 sat inc1", recCount, 255);
    cyc(5'b00100, 1'b0);
    chk("R3 fallback high", recCount, 120);

    // R6 passive through tec, R7 bus-off
    doReset();
    for (int i = 0; i < 16; i++) cyc(5'b00010, 1'b0);
    chk("R4 tec 128", tecCount, 128);
    flags("R6 passive tec", 0, 1, 0);
    for (int i = 0; i < 15; i++) cyc(5'b00010, 1'b0);
    chk("R4 tec 248", tecCount, 248);
    flags("R7 not yet off", 0, 1, 0);
    // R8 runs outside bus-off must not count
    for (int i = 0; i < 127; i++) cyc(5'b00000, 1'b1);
    cyc(5'b10010, 1'b0);
    chk("R7 tec 256", tecCount, 256);
    flags("R7 bus-off", 0, 0, 1);
    cyc(5'b01100, 1'b0);
    chk("R7 rec ignored", recCount, 1);
    cyc(5'b00011, 1'b0);
    chk("R7 tec ignored", tecCount, 256);
    cyc(5'b00000, 1'b1);
    chk("R8 early run no clear", tecCount, 256);
    flags("R8 still off", 0, 0, 1);

    // R8 recovery: 126 more runs keep bus-off, the 128th clears
    for (int i = 0; i < 126; i++) cyc(5'b00000, 1'b1);
    flags("R8 off after 127", 0, 0, 1);
    chk("R8 tec held", tecCount, 256);
    cyc(5'b00000, 1'b1);
    chk("R8 rec cleared", recCount, 0);
    chk("R8 tec cleared", tecCount, 0);
    flags("R8 active again", 1, 0, 0);
    cyc(5'b00010, 1'b0);
    chk("R8 commands resume", tecCount, 8);

    // R1 reset from busy state
    cyc(5'b01000, 1'b0);
    doReset();
    chk("R1 rec again", recCount, 0);
    chk("R1 tec again", tecCount, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule